// File: doc/BRIEF.md
# Software-Stepped I2C Slave Receiver

This block is the receive side of an I2C slave. Host software runs each bus phase by hand. It writes an operation code and pulses a go strobe to start one step: take in one byte, or drive one acknowledge bit. When the step ends, the block raises an event flag and reports a status code. If the bus master has already pulled SCL low, the block then holds SCL low, so the master waits until software starts the next step.

The block synchronizes both bus lines and detects START and STOP conditions itself. It compares the first byte after a START against its own 7-bit address. A match with a write direction bit lets the transaction go on. A mismatch silently drops the block back to waiting for the next START. Both lines are open-drain: each output is an enable that pulls the line low.

Top module: `i2cs_rx_stepper`

## Requirements
- R1: After reset the block releases both lines, and busy, the event flag, irq and the status code all read 0.
- R2: SDA falling while SCL is high is a START. It is reported as status 2 with the flag set, from any state. It cancels any running step and releases both lines.
- R3: SDA rising while SCL is high is a STOP. Inside a transaction it is reported as status 1, the running step is cancelled and both lines are released. A STOP outside a transaction raises no flag.
- R4: Operation code 3 receives one byte. Bits are sampled MSB first on SCL rising edges, and busy is high for the whole step. The byte appears on rx_byte together with status 3.
- R5: The first byte after a START is the address. Bits 7..1 must equal own_addr and bit 0 must be 0 (write). On any other value the block raises no flag, drives no acknowledge, does not hold SCL, and waits for a new START.
- R6: Operation code 4 drives one acknowledge bit. The line is pulled low if ack_nak=0 and left released if ack_nak=1. SDA changes only while SCL is low. After the SCL falling edge that closes the bit, the status is 4 for an ACK or 5 for a NAK.
- R7: Between steps the block holds SCL low once it sees SCL low, and keeps holding it until a valid go strobe arrives. After a NAK it does not hold SCL.
- R8: A go strobe counts only while the block waits between steps. Operation codes other than 3 and 4 are ignored: SCL stays held and busy stays 0.
- R9: Pulsing evt_clr clears the flag and returns the status code to 0. A new event in the same cycle takes priority.
- R10: irq always equals the event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| own_addr | input | 7 | Slave address to match |
| op_mode | input | 3 | Next step: 3 receive byte, 4 acknowledge |
| op_go | input | 1 | One-cycle strobe that starts the step |
| ack_nak | input | 1 | Level for step 4: 0 ACK, 1 NAK |
| busy | output | 1 | A step is in progress |
| evt_code | output | 3 | Status: 0 none, 1 STOP, 2 START, 3 byte, 4 ACK, 5 NAK |
| rx_byte | output | 8 | Last byte received |
| evt_flag | output | 1 | Event flag |
| evt_clr | input | 1 | One-cycle strobe that clears flag and status |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the corner cases where a step gets interrupted. A repeated START in the middle of a byte must abort the receive and re-arm address matching; a design that misses this keeps counting bits and reports a bogus byte. A STOP in the middle of a byte must release SCL, or the bus hangs. The bench also sends a foreign address and a read-direction address; a design that acknowledges either one, or holds SCL after it, would grab a bus that is not its own. The bench also issues a go strobe with an unknown operation code, which must leave SCL held. Every clock the bench checks that SDA only changes while SCL is low, since an ACK edge during SCL high would look like a false START or STOP.

// File: rtl/i2cs_rx_pkg.sv
package i2cs_rx_pkg;
  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_STOP  = 3'd1,
    EV_START = 3'd2,
    EV_BYTE  = 3'd3,
    EV_ACK   = 3'd4,
    EV_NAK   = 3'd5
  } ev_code_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RX,
    ST_ACK
  } ctl_state_t;

  localparam logic [2:0] OP_RX  = 3'd3;
  localparam logic [2:0] OP_ACK = 3'd4;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2cs_byte_shift.sv
module i2cs_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] byte_next,
  output logic         last
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  data_q, data_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    if (clr) begin
      data_d = '0;
      cnt_d  = '0;
    end else if (shift_en) begin
      data_d = byte_next;
      cnt_d  = (cnt_q == CW'(W-1)) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign byte_next = {data_q[W-2:0], bit_in};
  assign last      = (cnt_q == CW'(W-1));
endmodule

// File: rtl/i2cs_rx_stepper.sv
module i2cs_rx_stepper
  import i2cs_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  input  logic [2:0]        op_mode,
  input  logic              op_go,
  input  logic              ack_nak,
  output logic              busy,
  output logic [2:0]        evt_code,
  output logic [DATA_W-1:0] rx_byte,
  output logic              evt_flag,
  input  logic              evt_clr,
  output logic              irq
);
  logic scl_s, scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic sh_clr, sh_en, sh_last;
  logic [DATA_W-1:0] sh_byte;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_byte_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en),
    .bit_in(sda_s), .byte_next(sh_byte), .last(sh_last)
  );

  ctl_state_t        state_q, state_d;
  logic              xfer_q, xfer_d;
  logic              addr_q, addr_d;
  logic              hold_q, hold_d;
  logic              sdrv_q, sdrv_d;
  logic              arm_q, arm_d;
  logic              rose_q, rose_d;
  logic              nak_q, nak_d;
  logic              flag_q, flag_d;
  ev_code_t          code_q, code_d;
  logic [DATA_W-1:0] rxb_q, rxb_d;
  logic              ev_set;
  ev_code_t          ev_val;
  logic              go_valid, addr_hit;

  assign go_valid = op_go & ((op_mode == OP_RX) | (op_mode == OP_ACK));
  assign addr_hit = (sh_byte[DATA_W-1:1] == own_addr) & ~sh_byte[0];

  always_comb begin
    state_d = state_q;
    xfer_d  = xfer_q;
    addr_d  = addr_q;
    hold_d  = hold_q;
    sdrv_d  = sdrv_q;
    arm_d   = arm_q;
    rose_d  = rose_q;
    nak_d   = nak_q;
    rxb_d   = rxb_q;
    ev_set  = 1'b0;
    ev_val  = EV_NONE;
    sh_clr  = 1'b0;
    sh_en   = 1'b0;

    case (state_q)
      ST_WAIT: begin
        if (go_valid) begin
          if (op_mode == OP_RX) begin
            state_d = ST_RX;
            hold_d  = 1'b0;
            sh_clr  = 1'b1;
          end else begin
            state_d = ST_ACK;
            nak_d   = ack_nak;
            arm_d   = 1'b0;
            rose_d  = 1'b0;
          end
        end else if (!scl_s) begin
          hold_d = 1'b1;
        end
      end
      ST_RX: begin
        sh_en = scl_rise;
        if (scl_rise && sh_last) begin
          if (addr_q && !addr_hit) begin
            state_d = ST_IDLE;
            xfer_d  = 1'b0;
          end else begin
            state_d = ST_WAIT;
            addr_d  = 1'b0;
            rxb_d   = sh_byte;
            ev_set  = 1'b1;
            ev_val  = EV_BYTE;
          end
        end
      end
      ST_ACK: begin
        if (!arm_q) begin
          if (!scl_s) begin
            arm_d  = 1'b1;
            sdrv_d = ~nak_q;
          end
        end else begin
          hold_d = 1'b0;
          if (scl_rise) rose_d = 1'b1;
          if (rose_q && scl_fall) begin
            sdrv_d  = 1'b0;
            ev_set  = 1'b1;
            ev_val  = nak_q ? EV_NAK : EV_ACK;
            state_d = nak_q ? ST_IDLE : ST_WAIT;
          end
        end
      end
      default: ;
    endcase

    if (start_det) begin
      state_d = ST_WAIT;
      xfer_d  = 1'b1;
      addr_d  = 1'b1;
      hold_d  = 1'b0;
      sdrv_d  = 1'b0;
      ev_set  = 1'b1;
      ev_val  = EV_START;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      xfer_d  = 1'b0;
      hold_d  = 1'b0;
      sdrv_d  = 1'b0;
      if (xfer_q) begin
        ev_set = 1'b1;
        ev_val = EV_STOP;
      end
    end
  end

  always_comb begin
    flag_d = flag_q;
    code_d = code_q;
    if (ev_set) begin
      flag_d = 1'b1;
      code_d = ev_val;
    end else if (evt_clr) begin
      flag_d = 1'b0;
      code_d = EV_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      xfer_q  <= 1'b0;
      addr_q  <= 1'b0;
      hold_q  <= 1'b0;
      sdrv_q  <= 1'b0;
      arm_q   <= 1'b0;
      rose_q  <= 1'b0;
      nak_q   <= 1'b0;
      flag_q  <= 1'b0;
      code_q  <= EV_NONE;
      rxb_q   <= '0;
    end else begin
      state_q <= state_d;
      xfer_q  <= xfer_d;
      addr_q  <= addr_d;
      hold_q  <= hold_d;
      sdrv_q  <= sdrv_d;
      arm_q   <= arm_d;
      rose_q  <= rose_d;
      nak_q   <= nak_d;
      flag_q  <= flag_d;
      code_q  <= code_d;
      rxb_q   <= rxb_d;
    end
  end

  assign scl_oe   = hold_q;
  assign sda_oe   = sdrv_q;
  assign busy     = (state_q == ST_RX) | (state_q == ST_ACK);
  assign evt_code = code_q;
  assign rx_byte  = rxb_q;
  assign evt_flag = flag_q;
  assign irq      = flag_q;
endmodule

// File: rtl/i2cs_rx_checker.sv
module i2cs_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              busy,
  input logic              evt_flag,
  input logic [2:0]        evt_code,
  input logic [DATA_W-1:0] rx_byte,
  input logic              op_go,
  input logic [2:0]        op_mode
);
  AST_ACK_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i); // R6
  AST_CODE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_flag |-> (evt_code == 3'd0)); // R9
  AST_RX_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> (evt_flag && evt_code == 3'd3)); // R4
  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && !busy && op_mode != 3'd3 && op_mode != 3'd4) |=> !busy); // R8
  AST_RX_RELEASES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && op_mode == 3'd3 && !busy && scl_oe) |=> !scl_oe); // R7
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_code <= 3'd5); // R9
endmodule

bind i2cs_rx_stepper i2cs_rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .busy(busy), .evt_flag(evt_flag),
  .evt_code(evt_code), .rx_byte(rx_byte), .op_go(op_go),
  .op_mode(op_mode)
);

// File: tb/i2cs_rx_stepper_bench.sv
module i2cs_rx_stepper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 10;
  localparam logic [6:0] MY_ADDR = 7'h2A;

  logic clk, rst_n;
  logic m_scl, m_sda;
  logic scl_oe, sda_oe, busy, evt_flag, irq;
  logic [2:0] op_mode, evt_code;
  logic op_go, ack_nak, evt_clr;
  logic [7:0] rx_byte;
  wire scl_w = m_scl & ~scl_oe;
  wire sda_w = m_sda & ~sda_oe;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic prev_sdaoe;

  i2cs_rx_stepper u_i2cs_rx_stepper (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(MY_ADDR),
    .op_mode(op_mode), .op_go(op_go), .ack_nak(ack_nak),
    .busy(busy), .evt_code(evt_code), .rx_byte(rx_byte),
    .evt_flag(evt_flag), .evt_clr(evt_clr), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // every-clock model comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R10 irq", irq, evt_flag);
      if (!evt_flag) chk("R9 code idle", evt_code, 0);
      if (sda_oe != prev_sdaoe) chk("R6 sda edge scl low", scl_w, 0);
    end
    prev_sdaoe = sda_oe;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic hw(); repeat (H) @(negedge clk); endtask
  task automatic scl_up();
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_w) @(negedge clk);
    hw();
  endtask
  task automatic m_start(); m_sda = 1'b1; m_scl = 1'b1; hw(); m_sda = 1'b0; hw(); m_scl = 1'b0; hw(); endtask
  task automatic m_rstart(); m_sda = 1'b1; hw(); scl_up(); m_sda = 1'b0; hw(); m_scl = 1'b0; hw(); endtask
  task automatic m_stop(); m_sda = 1'b0; hw(); scl_up(); m_sda = 1'b1; hw(); endtask
  task automatic m_bit(input logic b); m_sda = b; hw(); scl_up(); m_scl = 1'b0; hw(); endtask
  task automatic m_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_bit(v[i]);
  endtask
  task automatic m_ack(input string req, input int exp);
    logic a;
    m_sda = 1'b1; hw();
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_w) @(negedge clk);
    repeat (H/2) @(negedge clk);
    a = sda_w;
    repeat (H/2) @(negedge clk);
    m_scl = 1'b0; hw();
    chk(req, a, exp);
  endtask

  task automatic sw_go(input logic [2:0] md, input logic nk, input string req, input int exp_busy);
    @(negedge clk); op_mode = md; ack_nak = nk; op_go = 1'b1;
    @(negedge clk); op_go = 1'b0;
    chk(req, busy, exp_busy);
  endtask
  task automatic sw_evt(input int code, input string req);
    int t = 0;
    while (!evt_flag && t < 20000) begin @(negedge clk); t++; end
    chk(req, evt_code, code);
    @(negedge clk); evt_clr = 1'b1;
    @(negedge clk); evt_clr = 1'b0;
    chk("R9 clear flag", evt_flag, 0);
    chk("R9 clear code", evt_code, 0);
  endtask

  initial begin
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    op_mode = 3'd0; op_go = 1'b0; ack_nak = 1'b0; evt_clr = 1'b0;
    prev_sdaoe = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy", busy, 0); chk("R1 flag", evt_flag, 0); chk("R1 code", evt_code, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // full write: address, two data bytes, ACK then NAK, STOP
    fork
      begin
        m_start(); m_byte({MY_ADDR, 1'b0}); m_ack("R6 addr ack", 0);
        m_byte(8'hA5); m_ack("R6 data ack", 0);
        m_byte(8'h3C); m_ack("R6 nak level", 1);
        m_stop();
      end
      begin
        sw_evt(2, "R2 start");
        repeat (30) @(negedge clk);
        chk("R7 held after start", scl_oe, 1);
        sw_go(3'd6, 1'b0, "R8 bad op busy", 0);
        repeat (30) @(negedge clk);
        chk("R8 still held", scl_oe, 1);
        sw_go(3'd3, 1'b0, "R4 busy addr", 1);
        sw_evt(3, "R4 addr byte"); chk("R5 addr value", rx_byte, {MY_ADDR, 1'b0});
        sw_go(3'd4, 1'b0, "R6 busy ack", 1);
        sw_evt(4, "R6 ack code");
        sw_go(3'd3, 1'b0, "R4 busy d0", 1);
        sw_evt(3, "R4 byte A5"); chk("R4 data A5", rx_byte, 8'hA5);
        sw_go(3'd4, 1'b0, "R6 busy ack2", 1);
        sw_evt(4, "R6 ack code2");
        sw_go(3'd3, 1'b0, "R4 busy d1", 1);
        sw_evt(3, "R4 byte 3C"); chk("R4 data 3C", rx_byte, 8'h3C);
        sw_go(3'd4, 1'b1, "R6 busy nak", 1);
        sw_evt(5, "R6 nak code");
        chk("R7 no hold after nak", scl_oe, 0);
        sw_evt(1, "R3 stop");
      end
    join
    repeat (20) @(negedge clk);

    // foreign address and read-direction address
    for (int k = 0; k < 2; k++) begin
      logic [7:0] a = (k == 0) ? {7'h15, 1'b0} : {MY_ADDR, 1'b1};
      fork
        begin m_start(); m_byte(a); m_ack("R5 no ack", 1); end
        begin sw_evt(2, "R2 start mm"); sw_go(3'd3, 1'b0, "R4 busy mm", 1); end
      join
      chk("R5 no flag", evt_flag, 0); chk("R5 no hold", scl_oe, 0);
      chk("R5 not busy", busy, 0); chk("R5 rx kept", rx_byte, 8'h3C);
      m_stop(); repeat (10) @(negedge clk);
      chk("R3 stop outside ignored", evt_flag, 0);
    end

    // repeated START mid-byte, then STOP mid-byte
    fork
      begin
        m_start(); m_byte({MY_ADDR, 1'b0}); m_ack("R6 ack rs", 0);
        m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_rstart();
        m_byte({MY_ADDR, 1'b0}); m_ack("R6 ack rs2", 0);
        m_bit(1'b0); m_bit(1'b1); m_stop();
      end
      begin
        sw_evt(2, "R2 start rs"); sw_go(3'd3, 1'b0, "R4 busy a", 1);
        sw_evt(3, "R4 addr rs"); sw_go(3'd4, 1'b0, "R6 busy a", 1);
        sw_evt(4, "R6 ack rs"); sw_go(3'd3, 1'b0, "R4 busy part", 1);
        sw_evt(2, "R2 restart cancels"); chk("R2 busy cleared", busy, 0);
        chk("R2 rx kept", rx_byte, {MY_ADDR, 1'b0});
        sw_go(3'd3, 1'b0, "R4 busy a2", 1);
        sw_evt(3, "R5 readdress"); sw_go(3'd4, 1'b0, "R6 busy a2", 1);
        sw_evt(4, "R6 ack a2"); sw_go(3'd3, 1'b0, "R4 busy part2", 1);
        sw_evt(1, "R3 stop cancels");
        chk("R3 busy cleared", busy, 0); chk("R3 scl released", scl_oe, 0);
        chk("R3 sda released", sda_oe, 0);
      end
    join

    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule